// File: doc/BRIEF.md
# Phased SPI Flash Command Engine

This block is a single-lane SPI master that runs one serial-flash transaction per start strobe. A transaction is built from up to five phases, always in this order: an 8-bit command byte, an address of programmable bit length, a run of dummy clocks, outgoing data, and incoming data. A phase whose length is zero is left out. The caller presents the command, the address and its length, a dummy count, the write word and its length, and the read length, then pulses `start`. When chip select has been released, `done` pulses and `rd_word` holds the assembled read result.

Dummy clocks are inserted only when the transaction reads something. In that case their number is the requested count plus a fixed extra latency set by a parameter, which covers the turnaround delay of the board and pad path. Read bytes are packed first byte into the low byte, and every result bit at or above the requested read length is cleared. A parameter-table read is one typical use: command 0x5A, a 24-bit address, 8 dummy clocks and 1 to 4 bytes returned.

The serial clock runs in SPI mode 0. A parameter sets its half-period in system clocks. The write-protect output stays high at all times, so the flash never sees a protected window in the middle of a command.

Top module: `spi_phase_engine`

## Requirements
- R1: Every transaction begins with the 8-bit `opcode`, sent most significant bit first. It is the only phase when all the other lengths are zero.
- R2: The address phase runs only when `addr_len` is nonzero. It sends the low `addr_len` bits of `addr`, most significant of those first. A length above 32 is treated as 32.
- R3: When `rd_len` is nonzero, exactly `dummy_cnt + EXTRA_DUMMY` dummy clocks follow the address, with MOSI low. When `rd_len` is zero, no dummy clock is issued, whatever `dummy_cnt` holds.
- R4: The write phase sends `wr_len` bits of `wr_data` (lengths above 32 are clamped to 32). Transmitted bit k is `wr_data[8*(k/8) + 7 - k%8]`, which puts byte 0 first with each byte MSB first. The phase is skipped when `wr_len` is zero.
- R5: The read phase samples `rd_len` bits (clamped to 32). Received bit k lands in `rd_word[8*(k/8) + 7 - k%8]`. Every bit of `rd_word` at or above `rd_len` is zero, so `rd_len` = 0 returns 0.
- R6: `wp` is high out of reset and through every transaction.
- R7: SPI mode 0. SCLK is low while idle. MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge. Each SCLK half-period lasts `CLK_DIV` system clocks. CS_n falls one half-period before the first rising edge.
- R8: A `start` strobe seen while `busy` is high is ignored. It neither changes the running transaction nor queues another one.
- R9: `done` is a one-cycle pulse in the cycle CS_n returns high, and `busy` falls in that same cycle. `rd_word` changes only in a `done` cycle.
- R10: After reset, `cs_n` is 1, `sclk` is 0, `busy` and `done` are 0, and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a transaction when idle |
| opcode | input | 8 | Command byte |
| addr | input | DATA_W | Address value (low bits used) |
| addr_len | input | clog2(DATA_W+1) | Address length in bits, 0 skips the phase |
| dummy_cnt | input | DUMMY_W | Requested dummy clocks |
| wr_data | input | DATA_W | Outgoing data word |
| wr_len | input | clog2(DATA_W+1) | Outgoing length in bits |
| rd_len | input | clog2(DATA_W+1) | Incoming length in bits |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | DATA_W | Masked read result |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| wp | output | 1 | Write-protect, held high |

## Verification
The assertions check the pin-level rules on every cycle: WP stays high while selected, SCLK is low whenever chip select is high or the block is idle, MOSI holds through each SCLK high time, `done` is a single pulse aligned with chip-select release, a start while busy leaves the block busy, and `rd_word` stays frozen outside `done`. Only the bench's scenarios can show the serial content of each phase. That covers skipping a zero-length phase, the extra dummy clocks appearing only with a read, clamping an over-long address, the byte order of write and read data, and masking of a read length that is not a whole number of bytes. A slave model in the bench captures every bit and replays a chosen MISO pattern for these checks.

// File: rtl/spi_phase_pkg.sv
package spi_phase_pkg;

  // Phase order is behaviour: the sequencer walks upward through these codes.
  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_WR    = 3'd3,
    PH_RD    = 3'd4,
    PH_NONE  = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_LOW  = 3'd2,
    ST_HIGH = 3'd3,
    ST_TAIL = 3'd4
  } state_e;

  localparam int NPH = 5;

  // First phase after cur whose length is nonzero, or PH_NONE.
  function automatic phase_e phase_after(phase_e cur, logic [NPH-1:0] present);
    phase_e r;
    r = PH_NONE;
    for (int k = NPH - 1; k >= 0; k--) begin
      if (k > int'(cur) && present[k]) r = phase_e'(3'(k));
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_phase_tick.sv
module spi_phase_tick #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)                 cnt_q <= '0;
    else if (cnt_q == CW'(CLK_DIV-1)) cnt_q <= '0;
    else                              cnt_q <= cnt_q + CW'(1);
  end

  assign tick = run && (cnt_q == CW'(CLK_DIV-1));
endmodule

// File: rtl/spi_phase_req.sv
module spi_phase_req
  import spi_phase_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DUMMY_W     = 8,
  parameter int EXTRA_DUMMY = 1,
  parameter int LEN_W       = 9,
  parameter int LFW         = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [7:0]           opcode,
  input  logic [DATA_W-1:0]    addr,
  input  logic [LFW-1:0]       addr_len,
  input  logic [DUMMY_W-1:0]   dummy_cnt,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [LFW-1:0]       wr_len,
  input  logic [LFW-1:0]       rd_len,
  input  phase_e               sel_phase,
  input  logic [LEN_W-1:0]     sel_idx,
  output logic [LEN_W-1:0]     len_addr,
  output logic [LEN_W-1:0]     len_dummy,
  output logic [LEN_W-1:0]     len_wr,
  output logic [LFW-1:0]       len_rd,
  output logic [NPH-1:0]       present,
  output logic                 sel_bit
);
  localparam int IW = $clog2(DATA_W);

  function automatic logic [LFW-1:0] clampw(logic [LFW-1:0] v);
    return (v > LFW'(DATA_W)) ? LFW'(DATA_W) : v;
  endfunction

  logic [7:0]        op_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [LFW-1:0]    alen_q, wlen_q, rlen_q;
  logic [LEN_W-1:0]  dum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      alen_q <= '0;
      wlen_q <= '0;
      rlen_q <= '0;
      dum_q  <= '0;
    end else if (load) begin
      op_q   <= opcode;
      addr_q <= addr;
      wdat_q <= wr_data;
      alen_q <= clampw(addr_len);
      wlen_q <= clampw(wr_len);
      rlen_q <= clampw(rd_len);
      dum_q  <= (rd_len != '0) ? (LEN_W'(dummy_cnt) + LEN_W'(EXTRA_DUMMY)) : '0;
    end
  end

  assign len_addr  = LEN_W'(alen_q);
  assign len_dummy = dum_q;
  assign len_wr    = LEN_W'(wlen_q);
  assign len_rd    = rlen_q;
  assign present   = {rlen_q != '0, wlen_q != '0, dum_q != '0, alen_q != '0, 1'b1};

  logic [LEN_W-1:0] apos;
  always_comb begin
    apos = LEN_W'(alen_q) - sel_idx - LEN_W'(1);
    case (sel_phase)
      PH_OPC:  sel_bit = op_q[~sel_idx[2:0]];
      PH_ADDR: sel_bit = addr_q[apos[IW-1:0]];
      PH_WR:   sel_bit = wdat_q[{sel_idx[IW-1:3], ~sel_idx[2:0]}];
      default: sel_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/spi_phase_rx.sv
module spi_phase_rx #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 9,
  parameter int LFW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [LEN_W-1:0]  bit_idx,
  input  logic              miso_in,
  input  logic              finish,
  input  logic [LFW-1:0]    rlen,
  output logic [DATA_W-1:0] rd_word
);
  localparam int IW = $clog2(DATA_W);

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] keep;

  always_ff @(posedge clk) begin
    if (rst || clear) shreg_q <= '0;
    else if (sample)  shreg_q[{bit_idx[IW-1:3], ~bit_idx[2:0]}] <= miso_in;
  end

  always_comb begin
    for (int b = 0; b < DATA_W; b++) keep[b] = (LFW'(b) < rlen);
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_word <= '0;
    else if (finish) rd_word <= shreg_q & keep;
  end
endmodule

// File: rtl/spi_phase_engine.sv
module spi_phase_engine
  import spi_phase_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DUMMY_W     = 8,
  parameter int EXTRA_DUMMY = 1,
  parameter int CLK_DIV     = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [7:0]                   opcode,
  input  logic [DATA_W-1:0]            addr,
  input  logic [$clog2(DATA_W+1)-1:0]  addr_len,
  input  logic [DUMMY_W-1:0]           dummy_cnt,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [$clog2(DATA_W+1)-1:0]  wr_len,
  input  logic [$clog2(DATA_W+1)-1:0]  rd_len,
  input  logic                         miso,
  output logic                         busy,
  output logic                         done,
  output logic [DATA_W-1:0]            rd_word,
  output logic                         sclk,
  output logic                         cs_n,
  output logic                         mosi,
  output logic                         wp
);
  localparam int LFW       = $clog2(DATA_W + 1);
  localparam int DUMMY_MAX = (1 << DUMMY_W) - 1 + EXTRA_DUMMY;
  localparam int DW        = $clog2(DUMMY_MAX + 1);
  localparam int LEN_W     = (DW > LFW) ? DW : LFW;

  state_e           st_q;
  phase_e           ph_q;
  logic [LEN_W-1:0] idx_q;

  logic             tick;
  logic             run;
  logic             load;
  logic [LEN_W-1:0] len_addr, len_dummy, len_wr, cur_len;
  logic [LFW-1:0]   len_rd;
  logic [NPH-1:0]   present;
  logic             last_bit;
  phase_e           adv_ph, sel_ph;
  logic [LEN_W-1:0] adv_idx, sel_idx;
  logic             sel_bit;

  assign run  = (st_q == ST_LOW) || (st_q == ST_HIGH) || (st_q == ST_TAIL);
  assign load = (st_q == ST_IDLE) && start;

  spi_phase_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk (clk), .rst (rst), .run (run), .tick (tick)
  );

  spi_phase_req #(
    .DATA_W(DATA_W), .DUMMY_W(DUMMY_W), .EXTRA_DUMMY(EXTRA_DUMMY),
    .LEN_W(LEN_W), .LFW(LFW)
  ) u_req (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .opcode    (opcode),
    .addr      (addr),
    .addr_len  (addr_len),
    .dummy_cnt (dummy_cnt),
    .wr_data   (wr_data),
    .wr_len    (wr_len),
    .rd_len    (rd_len),
    .sel_phase (sel_ph),
    .sel_idx   (sel_idx),
    .len_addr  (len_addr),
    .len_dummy (len_dummy),
    .len_wr    (len_wr),
    .len_rd    (len_rd),
    .present   (present),
    .sel_bit   (sel_bit)
  );

  spi_phase_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .LFW(LFW)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .clear   (load),
    .sample  (tick && (st_q == ST_LOW) && (ph_q == PH_RD)),
    .bit_idx (idx_q),
    .miso_in (miso),
    .finish  (tick && (st_q == ST_TAIL)),
    .rlen    (len_rd),
    .rd_word (rd_word)
  );

  always_comb begin
    case (ph_q)
      PH_OPC:   cur_len = LEN_W'(8);
      PH_ADDR:  cur_len = len_addr;
      PH_DUMMY: cur_len = len_dummy;
      PH_WR:    cur_len = len_wr;
      PH_RD:    cur_len = LEN_W'(len_rd);
      default:  cur_len = LEN_W'(1);
    endcase
    last_bit = (idx_q == cur_len - LEN_W'(1));
    if (last_bit) begin
      adv_ph  = phase_after(ph_q, present);
      adv_idx = '0;
    end else begin
      adv_ph  = ph_q;
      adv_idx = idx_q + LEN_W'(1);
    end
    if (st_q == ST_LOAD) begin
      sel_ph  = PH_OPC;
      sel_idx = '0;
    end else begin
      sel_ph  = adv_ph;
      sel_idx = adv_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_OPC;
      idx_q <= '0;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      mosi  <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      wp    <= 1'b1;
    end else begin
      done <= 1'b0;
      wp   <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q <= ST_LOAD;
            busy <= 1'b1;
          end
        end
        ST_LOAD: begin
          st_q  <= ST_LOW;
          cs_n  <= 1'b0;
          ph_q  <= PH_OPC;
          idx_q <= '0;
          mosi  <= sel_bit;
        end
        ST_LOW: begin
          if (tick) begin
            sclk <= 1'b1;
            st_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (adv_ph == PH_NONE) begin
              st_q <= ST_TAIL;
              mosi <= 1'b0;
            end else begin
              st_q  <= ST_LOW;
              ph_q  <= adv_ph;
              idx_q <= adv_idx;
              mosi  <= sel_bit;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n <= 1'b1;
            busy <= 1'b0;
            done <= 1'b1;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_phase_engine_chk.sv
module spi_phase_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rd_word,
  input logic              sclk,
  input logic              cs_n,
  input logic              mosi,
  input logic              wp
);
  assert_wp_high_R6: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> wp);

  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy && $past(busy)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_word));
endmodule

bind spi_phase_engine spi_phase_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .rd_word (rd_word),
  .sclk    (sclk),
  .cs_n    (cs_n),
  .mosi    (mosi),
  .wp      (wp)
);

// File: tb/spi_phase_engine_bench.sv
`timescale 1ns/1ps
module spi_phase_engine_bench;
  localparam int DIV   = 2;
  localparam int EXTRA = 1;
  localparam int PER   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [31:0] addr = '0;
  logic [5:0]  addr_len = '0;
  logic [7:0]  dummy_cnt = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  wr_len = '0;
  logic [5:0]  rd_len = '0;
  logic        miso;
  logic        busy, done, sclk, cs_n, mosi, wp;
  logic [31:0] rd_word;

  int n_chk = 0;
  int n_bad = 0;

  always #(PER/2) clk = ~clk;

  spi_phase_engine #(.DATA_W(32), .DUMMY_W(8), .EXTRA_DUMMY(EXTRA), .CLK_DIV(DIV))
  u_spi_phase_engine (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .addr(addr),
    .addr_len(addr_len), .dummy_cnt(dummy_cnt), .wr_data(wr_data),
    .wr_len(wr_len), .rd_len(rd_len), .miso(miso), .busy(busy), .done(done),
    .rd_word(rd_word), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .wp(wp)
  );

  // Slave model: logs MOSI on rising SCLK, replays src on MISO.
  logic [511:0] mlog;
  logic [511:0] src = '0;
  int  nbits = 0;
  int  frames = 0;
  time t_csfall = 0, t_rise = 0, gap = 0, hi_len = 0;
  int  glitch = 0;

  always_comb miso = (nbits < 512) ? src[nbits] : 1'b0;

  always @(negedge cs_n or posedge sclk) begin
    if (sclk) begin
      if (!cs_n) begin
        if (nbits == 0) gap = $time - t_csfall;
        t_rise = $time;
        if (nbits < 512) mlog[nbits] = mosi;
        nbits = nbits + 1;
      end
    end else begin
      frames = frames + 1;
      nbits = 0;
      t_csfall = $time;
    end
  end

  always @(negedge sclk) if (!cs_n) hi_len = $time - t_rise;
  always @(mosi) if (sclk === 1'b1 && cs_n === 1'b0) glitch = glitch + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one transaction and checks bit stream, result and done pulse.
  task automatic run_txn(input string req, input logic [7:0] op,
                         input logic [31:0] a, input int alen, input int dcnt,
                         input logic [31:0] wd, input int wlen, input int rlen);
    logic [511:0] exp;
    logic [31:0]  rexp;
    int n, base, ea, ed, ew, er, miss, f0, wait_c;
    n = 0; exp = '0; rexp = '0;
    ea = (alen > 32) ? 32 : alen;
    ew = (wlen > 32) ? 32 : wlen;
    er = (rlen > 32) ? 32 : rlen;
    ed = (er > 0) ? dcnt + EXTRA : 0;
    for (int i = 0; i < 8; i++)  begin exp[n] = op[7-i]; n++; end
    for (int i = 0; i < ea; i++) begin exp[n] = a[ea-1-i]; n++; end
    for (int i = 0; i < ed; i++) begin exp[n] = 1'b0; n++; end
    for (int i = 0; i < ew; i++) begin exp[n] = wd[8*(i/8) + 7 - i%8]; n++; end
    base = n;
    for (int i = 0; i < er; i++) begin exp[n] = 1'b0; n++; end
    for (int k = 0; k < er; k++) begin
      int pos;
      pos = 8*(k/8) + 7 - k%8;
      if (pos < er) rexp[pos] = src[base+k];
    end
    f0 = frames;
    @(negedge clk);
    opcode = op; addr = a; addr_len = 6'(alen); dummy_cnt = 8'(dcnt);
    wr_data = wd; wr_len = 6'(wlen); rd_len = 6'(rlen); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_c = 0;
    while (!done && wait_c < 20000) begin @(negedge clk); wait_c++; end
    check(done === 1'b1, req, "done seen", 64'(done), 64'd1);
    check(cs_n === 1'b1 && busy === 1'b0, "R9", "cs_n/busy at done",
          {62'd0, cs_n, busy}, 64'h2);
    check(frames == f0 + 1, req, "frame count", 64'(frames - f0), 64'd1);
    check(nbits == n, req, "bit count", 64'(nbits), 64'(n));
    miss = 0;
    for (int i = 0; i < n; i++) if (mlog[i] !== exp[i]) miss++;
    check(miss == 0, req, "mosi stream mismatches", 64'(miss), 64'd0);
    check(rd_word === rexp, req, "rd_word", 64'(rd_word), 64'(rexp));
    check(wp === 1'b1, "R6", "wp", 64'(wp), 64'd1);
    @(negedge clk);
    check(done === 1'b0, "R9", "done width", 64'(done), 64'd0);
    check(rd_word === rexp, "R9", "rd_word held", 64'(rd_word), 64'(rexp));
  endtask

  task automatic t_reset();
    check(cs_n === 1'b1 && sclk === 1'b0, "R10", "cs_n/sclk", {62'd0, cs_n, sclk}, 64'h2);
    check(busy === 1'b0 && done === 1'b0, "R10", "busy/done", {62'd0, busy, done}, 64'h0);
    check(rd_word === 32'd0, "R10", "rd_word", 64'(rd_word), 64'd0);
    check(wp === 1'b1, "R6", "wp in reset", 64'(wp), 64'd1);
  endtask

  task automatic t_opcode_only();
    src = '0;
    run_txn("R1", 8'hA5, 32'h0, 0, 7, 32'h0, 0, 0);  // R3: dummy_cnt ignored
  endtask

  task automatic t_param_read();
    src = {16{32'hC3A5_96E1}};
    run_txn("R2", 8'h5A, 32'h0000_0010, 24, 8, 32'h0, 0, 8);
    run_txn("R3", 8'h5A, 32'h0000_0020, 24, 8, 32'h0, 0, 32);
  endtask

  task automatic t_write_only();
    src = '1;
    run_txn("R4", 8'h02, 32'h0012_3456, 24, 5, 32'hDEAD_BEEF, 32, 0);
    run_txn("R4", 8'h06, 32'h0, 0, 0, 32'h0000_81F0, 12, 0);
  endtask

  task automatic t_reads();
    src = {8{64'h0123_4567_89AB_CDEF}};
    run_txn("R5", 8'h9F, 32'h0, 0, 0, 32'h0, 0, 24);
    run_txn("R5", 8'h9F, 32'h0, 0, 2, 32'h0, 0, 12);
    run_txn("R5", 8'h35, 32'h0, 0, 0, 32'h0000_00AA, 8, 40);
  endtask

  task automatic t_addr_clamp();
    src = '0;
    run_txn("R2", 8'h03, 32'h8000_0001, 40, 0, 32'h0, 0, 0);
    run_txn("R2", 8'h0B, 32'hFFFF_FF5A, 7, 3, 32'h0, 0, 16);
  endtask

  task automatic t_timing();
    src = '0;
    glitch = 0;
    run_txn("R7", 8'h3C, 32'h0000_00F0, 8, 1, 32'h0, 0, 8);
    check(gap == time'(DIV*PER), "R7", "cs fall to first rise", 64'(gap), 64'(DIV*PER));
    check(hi_len == time'(DIV*PER), "R7", "sclk high time", 64'(hi_len), 64'(DIV*PER));
    check(glitch == 0, "R7", "mosi changes while sclk high", 64'(glitch), 64'd0);
  endtask

  task automatic t_busy_start();
    int f0;
    src = '0;
    f0 = frames;
    fork
      run_txn("R8", 8'h81, 32'h0000_1234, 16, 0, 32'h0, 0, 0);
      begin
        repeat (20) @(negedge clk);
        opcode = 8'h7E; addr_len = 6'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; opcode = 8'h81; addr_len = 6'd16;
      end
    join
    repeat (60) @(negedge clk);
    check(frames == f0 + 1, "R8", "frames after busy start", 64'(frames - f0), 64'd1);
    check(busy === 1'b0 && cs_n === 1'b1, "R8", "idle after", {62'd0, busy, cs_n}, 64'h1);
  endtask

  initial begin
    #(200000 * PER);
    n_bad++;
    $display("FAIL R9 watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_opcode_only();
    t_param_read();
    t_write_only();
    t_reads();
    t_addr_clamp();
    t_timing();
    t_busy_start();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule